// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast system clock into an enable pulse at sixteen times a serial line's bit rate. Transmit and receive logic both use the pulse as their oversampling strobe. The clock does not have to be a whole multiple of sixteen times the bit rate. Instead of a plain divider, a wrapping accumulator adds a small step value each clock. When the accumulator reaches a threshold, the block removes the threshold from it and emits a one-cycle pulse. Over the long run the pulse rate is then exactly clock × step / (threshold + step).

The step and the threshold are live input signals. Software or a parent block derives them once per line rate. Let G be the greatest common divisor of the clock frequency and sixteen times the bit rate. The step is sixteen times the bit rate divided by G. The threshold is the clock frequency divided by G, minus the step. A 100 MHz clock with a 9600 bit/s line gives G = 6400, a step of 24 (0x18) and a threshold of 15601 (0x3CF1).

Top module: `baud_frac_tick`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is 0 and the accumulator holds 0, whatever the step and threshold inputs are.
- R2: When the threshold is at least the step and both inputs are held constant, `tick_o` is never high in two consecutive cycles.
- R3: The decision at each rising edge works as follows. If the accumulator is at or above `limit_i`, the threshold is subtracted from it and `tick_o` is 1 for the following cycle. Otherwise `step_i` is added to it and `tick_o` is 0 for the following cycle.
- R4: The inputs must satisfy `limit_i + step_i <= 2**ACC_W`. With constant inputs under that condition, any window of `limit_i + step_i` consecutive cycles contains exactly `step_i` ticks.
- R5: With step 24 and threshold 15601, every window of 15625 clocks contains exactly 24 ticks.
- R6: After reset is released with step > 0 and threshold > 0, the first tick is visible after rising edge number ceil(threshold / step) + 1. The count starts at 1 with the first edge after release.
- R7: A step of 0 with a nonzero threshold produces no tick at all.
- R8: A threshold of 0 makes `tick_o` high in every cycle after the first edge following reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | ACC_W | Amount added to the accumulator on a non-tick cycle |
| limit_i | input | ACC_W | Threshold that causes a tick; subtracted on a tick |
| tick_o | output | 1 | One-cycle oversampling enable |

## Verification
The hardest property to reach from the ports is the exact long-run rate at the real line settings. At those settings the tick pattern only repeats after thousands of clocks, and the gaps between ticks alternate irregularly between two lengths. The stimulus holds the 9600 bit/s constants through two full 15625-clock windows and counts the ticks in each one. The same counting method is also applied to small step and threshold pairs, where one period is short enough that the exact bit-by-bit tick pattern after reset can be compared as well.

// File: rtl/baud_frac_pkg.sv
package baud_frac_pkg;
    // Default accumulator width; fits thresholds for common clocks and line rates.
    parameter int unsigned DEF_ACC_W = 16;
endpackage

// File: rtl/baud_frac_cmp.sv
module baud_frac_cmp #(
    parameter int unsigned ACC_W = baud_frac_pkg::DEF_ACC_W
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] limit_i,
    output logic             reached_o
);
    // Threshold reached: this edge subtracts instead of adding.
    always_comb begin
        reached_o = (acc_i >= limit_i);
    end
endmodule

// File: rtl/baud_frac_update.sv
module baud_frac_update #(
    parameter int unsigned ACC_W = baud_frac_pkg::DEF_ACC_W
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] step_i,
    input  logic [ACC_W-1:0] limit_i,
    input  logic             reached_i,
    output logic [ACC_W-1:0] acc_o
);
    logic [ACC_W-1:0] sum_w;
    logic [ACC_W-1:0] diff_w;

    always_comb begin
        sum_w  = acc_i + step_i;
        diff_w = acc_i - limit_i;
        acc_o  = reached_i ? diff_w : sum_w;
    end
endmodule

// File: rtl/baud_frac_tick.sv
module baud_frac_tick #(
    parameter int unsigned ACC_W = baud_frac_pkg::DEF_ACC_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [ACC_W-1:0] step_i,
    input  logic [ACC_W-1:0] limit_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic             reached_w;
    logic [ACC_W-1:0] acc_next_w;

    baud_frac_cmp #(.ACC_W(ACC_W)) u_cmp (
        .acc_i     (state_q.acc),
        .limit_i   (limit_i),
        .reached_o (reached_w)
    );

    baud_frac_update #(.ACC_W(ACC_W)) u_upd (
        .acc_i     (state_q.acc),
        .step_i    (step_i),
        .limit_i   (limit_i),
        .reached_i (reached_w),
        .acc_o     (acc_next_w)
    );

    always_comb begin
        state_d      = state_q;
        state_d.acc  = acc_next_w;
        state_d.tick = reached_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tick_o = state_q.tick;

    // R3: a tick only follows an edge where the accumulator had reached the threshold
    a_r3_tick_needs_reach: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> ($past(state_q.acc) >= $past(limit_i)));

    // R3: below the threshold there is no tick on the next cycle
    a_r3_quiet_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && ($past(state_q.acc) < $past(limit_i))) |-> !tick_o);

    // R8: a zero threshold ticks on every cycle
    a_r8_zero_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && ($past(limit_i) == '0)) |-> tick_o);

    // R2: no back-to-back ticks while the threshold is at least the step and inputs hold
    a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(tick_o) && $past(rst_ni) && $stable(step_i) && $stable(limit_i)
         && ($past(limit_i) >= $past(step_i))
         && ({1'b0, $past(state_q.acc)} < ({1'b0, $past(limit_i)} + {1'b0, $past(step_i)})))
        |-> !tick_o);

    // R1: reset holds the output low
    a_r1_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |-> !tick_o);
endmodule

// File: tb/baud_frac_tick_test.sv
module baud_frac_tick_test;
    localparam int CLK_PERIOD = 10;
    localparam int ACC_W = 16;
    localparam int NVEC = 5;
    // step, threshold
    localparam int unsigned VEC [NVEC][2] = '{
        '{24, 15601},
        '{1, 3},
        '{5, 11},
        '{16, 16},
        '{3, 7}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ACC_W-1:0] step = '0;
    logic [ACC_W-1:0] limit = '0;
    logic             tick;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_frac_tick #(.ACC_W(ACC_W)) uut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .step_i  (step),
        .limit_i (limit),
        .tick_o  (tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart(input int s, input int l);
        @(negedge clk);
        rst_n = 1'b0;
        step  = ACC_W'(s);
        limit = ACC_W'(l);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state, even with a zero threshold present
        step  = 16'd1;
        limit = 16'd0;
        repeat (3) @(negedge clk);
        check("R1", int'(tick), 0);
        repeat (2) @(negedge clk);
        check("R1", int'(tick), 0);

        // R4 / R5 / R2: counting windows from the vector table
        for (int v = 0; v < NVEC; v++) begin
            int win;
            int cnt1;
            int cnt2;
            int pairs;
            bit prev;
            win = int'(VEC[v][0] + VEC[v][1]);
            restart(int'(VEC[v][0]), int'(VEC[v][1]));
            cnt1 = 0; cnt2 = 0; pairs = 0; prev = 1'b0;
            for (int c = 0; c < 2 * win; c++) begin
                @(negedge clk);
                if (tick) begin
                    if (c < win) cnt1++; else cnt2++;
                    if (prev) pairs++;
                end
                prev = tick;
            end
            check(v == 0 ? "R5" : "R4", cnt1, int'(VEC[v][0]));
            check(v == 0 ? "R5" : "R4", cnt2, int'(VEC[v][0]));
            check("R2", pairs, 0);
        end

        // R3: exact pattern for step 5, threshold 11: ticks after edges 4,7,10,13,16
        begin
            int mism;
            bit expb;
            restart(5, 11);
            mism = 0;
            for (int e = 1; e <= 16; e++) begin
                @(negedge clk);
                expb = (e % 3 == 1) && (e >= 4);
                if (tick != expb) mism++;
            end
            check("R3", mism, 0);
        end

        // R6: first tick after edge ceil(l/s)+1
        begin
            int first;
            restart(1, 3);
            first = 0;
            for (int e = 1; e <= 10 && first == 0; e++) begin
                @(negedge clk);
                if (tick) first = e;
            end
            check("R6", first, 4);
            restart(24, 15601);
            first = 0;
            for (int e = 1; e <= 700 && first == 0; e++) begin
                @(negedge clk);
                if (tick) first = e;
            end
            check("R6", first, 652);
        end

        // R7: zero step never ticks
        begin
            int cnt;
            restart(0, 9);
            cnt = 0;
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                if (tick) cnt++;
            end
            check("R7", cnt, 0);
        end

        // R8: zero threshold ticks every cycle
        begin
            int cnt;
            restart(7, 0);
            cnt = 0;
            for (int c = 0; c < 50; c++) begin
                @(negedge clk);
                if (tick) cnt++;
            end
            check("R8", cnt, 50);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule